// File: doc/BRIEF.md
# Run-Time Selectable Boxcar Averager

This block smooths a stream of 14-bit two's complement samples with an equal-weight moving average. The averaging window holds 2^M samples. M comes from a 4-bit control input and can change while the stream is running. Because the window is always a power of two, the mean is the running sum shifted right by M. No divider is needed. The frequency response is that of an ideal boxcar filter. Its magnitude follows sin(N·π·f·tS) / (N·sin(π·f·tS)).

Each accepted input sample produces one filtered output sample with a matching valid strobe. The strobe comes exactly one clock later. The history buffer is sized for the longest window, 256 samples. A running sum is updated incrementally: the newest sample is added and the sample leaving the window is subtracted. Any change of the effective window length restarts the average from an empty history.

Top module: `boxcar_avg`

## Requirements
- R1: During and directly after reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in the clock cycle after each cycle in which `in_valid` is high. It is low in every other cycle.
- R3: With `avg_log2` = 0, the window is one sample long, and `out_data` equals the `in_data` accepted one clock earlier.
- R4: `out_data` is the sum of the most recent 2^M accepted samples divided by 2^M. The result is rounded toward minus infinity and given as 14-bit two's complement.
- R5: After reset or after a window change, window positions that have not yet received a sample count as zero.
- R6: A change of the effective M empties the history and the sum. The sample accepted in that same cycle is the first one in the new window.
- R7: `avg_log2` values 9 to 15 act as 8, which is a 256-sample window. A change between two values that both act as 8 does not empty the history.
- R8: A full 256-sample window of either extreme value (+8191 or -8192) returns that same value without overflow.
- R9: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R10: Cycles with `in_valid` low do not add to or advance the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avg_log2 | input | 4 | Window exponent M; window = 2^M, values above 8 act as 8 |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 14 | Input sample, two's complement |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | 14 | Windowed mean, two's complement |

## Verification
A fault in the fill count or in the read pointer of the history buffer is easy to spot. The first wrong output appears when the window first fills, because that is when the subtraction of the leaving sample starts. A stale running sum after a window change shows up on the very next strobe. It appears as an offset that never goes away, since the incremental update has no way to repair itself. The bench therefore compares every strobe against a mean that it recomputes from scratch. It also crosses windows with short and full lengths, gaps in the stream and extreme input values, so that such errors surface within one window length.

// File: rtl/boxcar_avg_pkg.sv
package boxcar_avg_pkg;

  // Effective exponent: requests above the limit are held at the limit.
  function automatic int clamp_log2(input int req, input int lmax);
    return (req > lmax) ? lmax : req;
  endfunction

  // Number of samples in a window of exponent m.
  function automatic int win_len(input int m);
    return 1 << m;
  endfunction

endpackage

// File: rtl/boxcar_avg_hist.sv
module boxcar_avg_hist #(
  parameter int DATA_W  = 14,
  parameter int LOG_MAX = 8,
  parameter int LOG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [LOG_W-1:0]  m_eff,
  output logic [DATA_W-1:0] leave_data
);
  localparam int DEPTH = 1 << LOG_MAX;
  localparam int PTR_W = LOG_MAX;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W:0]    win_ext;
  logic [PTR_W-1:0]  rd_idx;

  // The sample leaving the window was written 2^m pushes ago.
  // For the full depth this is the slot about to be overwritten.
  assign win_ext    = (PTR_W+1)'(1) << m_eff;
  assign rd_idx     = wr_ptr - win_ext[PTR_W-1:0];
  assign leave_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    wr_ptr <= '0;
    else if (push) wr_ptr <= wr_ptr + PTR_W'(1);
  end

endmodule

// File: rtl/boxcar_avg_fill.sv
module boxcar_avg_fill #(
  parameter int LOG_MAX = 8,
  parameter int LOG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LOG_W-1:0] m_eff,
  output logic             win_clear,
  output logic             win_full
);
  localparam int FILL_W = LOG_MAX + 1;

  logic [LOG_W-1:0]  m_q;
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_base;
  logic [FILL_W-1:0] win_ext;

  assign win_clear = (m_eff != m_q);
  assign fill_base = win_clear ? '0 : fill_q;
  assign win_ext   = FILL_W'(1) << m_eff;
  assign win_full  = (fill_base == win_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q    <= '0;
      fill_q <= '0;
    end else begin
      m_q <= m_eff;
      if (push && !win_full) fill_q <= fill_base + FILL_W'(1);
      else                   fill_q <= fill_base;
    end
  end

  // R5: the count of filled slots never exceeds the current window.
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= (FILL_W'(1) << m_q));

  // R6: a change of exponent leaves no filled slot behind.
  p_clear_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_clear && !push) |=> (fill_q == '0));

endmodule

// File: rtl/boxcar_avg_acc.sv
module boxcar_avg_acc #(
  parameter int DATA_W  = 14,
  parameter int LOG_MAX = 8,
  parameter int LOG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              win_clear,
  input  logic              win_full,
  input  logic [LOG_W-1:0]  m_eff,
  input  logic [DATA_W-1:0] new_data,
  input  logic [DATA_W-1:0] leave_data,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int ACC_W = DATA_W + LOG_MAX;

  // Mean of a window: arithmetic shift keeps the two's complement form.
  function automatic logic [DATA_W-1:0] mean_of(
    input logic signed [ACC_W-1:0] a, input logic [LOG_W-1:0] m);
    logic signed [ACC_W-1:0] s;
    s = a >>> m;
    return s[DATA_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc_q, acc_base, acc_next, new_ext, old_ext;
  logic signed [ACC_W-1:0] acc_scaled;
  logic                    fits_w;

  assign new_ext  = ACC_W'($signed(new_data));
  assign old_ext  = win_full ? ACC_W'($signed(leave_data)) : '0;
  assign acc_base = win_clear ? '0 : acc_q;
  assign acc_next = acc_base + new_ext - old_ext;

  assign acc_scaled = acc_q >>> m_eff;
  assign fits_w     = (acc_scaled[ACC_W-1:DATA_W-1] == '0) ||
                      (acc_scaled[ACC_W-1:DATA_W-1] == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= push;
      if (push) begin
        acc_q    <= acc_next;
        res_data <= mean_of(acc_next, m_eff);
      end else if (win_clear) begin
        acc_q <= '0;
      end
    end
  end

  // R6: a window change with no sample leaves an empty sum.
  p_clear_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_clear && !push) |=> (acc_q == '0));

  // R8: the stored sum divided by the window stays inside the sample range.
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_clear |-> fits_w);

endmodule

// File: rtl/boxcar_avg.sv
module boxcar_avg #(
  parameter int DATA_W  = 14,
  parameter int CTRL_W  = 4,
  parameter int LOG_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] avg_log2,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  import boxcar_avg_pkg::*;

  localparam int LOG_W = $clog2(LOG_MAX + 1);

  logic [LOG_W-1:0]  m_eff;
  logic              win_clear;
  logic              win_full;
  logic [DATA_W-1:0] leave_data;

  assign m_eff = LOG_W'(clamp_log2(int'(avg_log2), LOG_MAX));

  boxcar_avg_hist #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .push_data(in_data),
    .m_eff(m_eff), .leave_data(leave_data));

  boxcar_avg_fill #(.LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .m_eff(m_eff),
    .win_clear(win_clear), .win_full(win_full));

  boxcar_avg_acc #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .win_clear(win_clear),
    .win_full(win_full), .m_eff(m_eff), .new_data(in_data),
    .leave_data(leave_data), .res_valid(out_valid), .res_data(out_data));

  // R2: every sample yields a strobe one clock later, and nothing else does.
  p_strobe_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: the result holds between strobes.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R3: a one-sample window passes the sample through.
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && avg_log2 == '0) |=> (out_data == $past(in_data)));

endmodule

// File: tb/boxcar_avg_tb_top.sv
`timescale 1ns/1ps
module boxcar_avg_tb_top;
  localparam int DW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    avg_log2 = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  boxcar_avg dut_i (.clk(clk), .rst_n(rst_n), .avg_log2(avg_log2),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  typedef struct { int val; string tag; } exp_t;
  exp_t sb[$];
  int   hist[$];
  int   cur_m = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  int   last_out = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    if (v >= 8) return 8;
    return v;
  endfunction

  // Mean computed from the stored history with floor division.
  function automatic int model_mean();
    int w = 1;
    int s = 0;
    for (int k = 0; k < cur_m; k++) w = w * 2;
    for (int i = 0; i < w; i++) if (i < hist.size()) s += hist[i];
    if (s >= 0) return s / w;
    return -((-s + w - 1) / w);
  endfunction

  task automatic set_m(input int v);
    @(negedge clk);
    avg_log2 = v[3:0];
    if (eff(v) != cur_m) hist.delete();
    cur_m = eff(v);
  endtask

  // Drive at the current negedge; pulse ends at the next negedge.
  task automatic send(input int d, input string tag);
    exp_t e;
    in_valid = 1'b1;
    in_data  = d[DW-1:0];
    hist.push_front(d);
    if (hist.size() > 256) void'(hist.pop_back());
    e.val = model_mean();
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare every strobe against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'($signed(out_data)) == e.val, e.tag, int'($signed(out_data)), e.val);
        end
        last_out = int'($signed(out_data));
      end else begin
        check(int'($signed(out_data)) == last_out, "R9 hold",
              int'($signed(out_data)), last_out);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_data == '0, "R1 reset data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset valid", int'(out_valid), 0);
    check(out_data == '0, "R1 after reset data", int'(out_data), 0);
    mon_on = 1'b1;

    // R3 pass-through
    set_m(0);
    send(100, "R3 pass"); send(-5, "R3 pass"); send(8191, "R3 pass");
    send(-8192, "R3 pass"); send(7, "R3 pass");

    // R4/R5 window of 4, partial fill then full
    set_m(2);
    send(40, "R5 partial"); send(-12, "R5 partial"); send(9, "R5 partial");
    send(3, "R4 full"); send(-100, "R4 full"); send(77, "R4 full");
    send(-3, "R4 full"); send(1000, "R4 full");

    // R10 gaps do not advance the window
    send(20, "R10 gap"); idle(3); send(-40, "R10 gap"); idle(1);
    send(6, "R10 gap"); idle(5); send(2, "R10 gap");

    // R6 change clears history; sample in the same cycle starts the window
    set_m(3);
    send(-1, "R6 restart"); send(0, "R4 floor"); send(0, "R4 floor");
    send(5, "R6 partial"); send(-9, "R6 partial");
    set_m(3);
    send(11, "R6 same m keeps"); idle(2);
    set_m(1); idle(2);
    send(50, "R6 change idle"); send(51, "R6 change idle"); send(-7, "R4 w2");

    // R7/R8 clamped window, positive extreme
    set_m(12);
    for (int i = 0; i < 300; i++) send(8191, "R8 max");
    set_m(9);
    send(-8192, "R7 no clear"); send(0, "R7 no clear");
    set_m(15);
    for (int i = 0; i < 300; i++) send(-8192, "R8 min");
    set_m(8);
    send(123, "R7 eight vs clamp");

    // R5 fill after a change from the long window
    set_m(4);
    for (int i = 0; i < 20; i++) send((i * 37) % 200 - 100, "R5 w16");
    idle(3);

    check(sb.size() == 0, "R2 missing strobes", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule